// File: doc/BRIEF.md
# Framed Synchronous Serial Transceiver

This block moves 8-bit characters over a clocked serial link, least significant bit first, and can sit on either end of that link. As clock master it divides the system clock to produce the serial clock. As slave it synchronises an external serial clock and shifts on the edges it detects. Transmit and receive share one frame, so every frame carries one character each way (full duplex).

A frame is either the bare eight data bits or an asynchronous-style frame. The framed form is a 0 start bit, the data, an optional even or odd parity bit, and one or two 1 stop bits. The serial clock can be inverted. Without inversion the clock idles high, data is driven on the falling edge and sampled on the rising edge. With inversion the clock idles low and the two edges swap roles. In both cases the first edge after idle is the drive edge, and every bit slot ends with the clock back at its mark level.

The control path is a three-state machine. IDLE holds the transmitter ready. SHIFT runs the bit slots of one frame. DONE is a one-cycle closing state. The transitions are:
- IDLE→SHIFT on an accepted byte, or on a slave drive edge with no byte waiting.
- SHIFT→DONE on the sample edge of the last bit.
- DONE→IDLE unconditionally.

Top module: `sync_serial_xcvr`

## Requirements
- R1: Data is 8 bits sent and received LSB first. With `cfg_frame_en`=0 the frame is exactly D0..D7: 8 clock cycles and 8 line bits.
- R2: With `cfg_frame_en`=1 the line carries start bit 0, then D0..D7, then stop bits of value 1. `cfg_two_stop`=1 gives two stop bits and 0 gives one.
- R3: With framing on and `cfg_par_en`=1, a parity bit follows D7 and precedes the stops. `cfg_par_odd`=0 selects even parity (data plus parity has an even count of ones) and 1 selects odd. With framing off, `cfg_par_en` has no effect.
- R4: `rx_par_err` is 1 on a received frame whose parity bit does not match the selected parity. Otherwise it is 0.
- R5: `rx_frm_err` is 1 on a received frame with any stop bit at 0. Otherwise it is 0.
- R6: In master mode `sck_oe`=1 and, outside a frame, `sck_out` rests at 1 when `cfg_clk_inv`=0 and at 0 when it is 1. In slave mode `sck_oe`=0.
- R7: In master mode each serial clock half period lasts `cfg_half_div`+1 system clocks. The clock toggles only inside a frame, giving one full cycle per frame bit.
- R8: The receiver samples on the rising serial clock edge when `cfg_clk_inv`=0 and on the falling edge when it is 1. The transmitter changes `sd_out` on the opposite edge. In slave mode this holds for the synchronised `sck_in`.
- R9: `tx_ready` is 1 only in IDLE. A byte is taken when `tx_valid` and `tx_ready` are both 1, and `tx_ready` is 0 in the next cycle.
- R10: Each completed frame gives exactly one single-cycle `rx_valid` pulse, with `rx_data`, `rx_par_err` and `rx_frm_err` valid during it.
- R11: A slave clocked with no byte accepted transmits the character 0xFF, framed as configured.
- R12: `sd_out` is 1 at reset and throughout IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_master | input | 1 | 1: generate the serial clock; 0: follow `sck_in` |
| cfg_frame_en | input | 1 | 1: add start/stop framing |
| cfg_par_en | input | 1 | 1: add a parity bit (framed only) |
| cfg_par_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| cfg_clk_inv | input | 1 | Serial clock inversion |
| cfg_half_div | input | DIV_W | Master half period minus one, in system clocks |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle received-byte strobe |
| rx_par_err | output | 1 | Parity mismatch on the received frame |
| rx_frm_err | output | 1 | Stop bit received as 0 |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |
| sck_in | input | 1 | Serial clock in (slave) |
| sck_out | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |

## Verification
Several properties are checked on every cycle:
- the single-cycle receive strobe;
- the handshake dropping `tx_ready` after an accepted byte;
- the bit counter staying inside the longest frame;
- `sd_out` resting high in IDLE;
- the master clock's mark level while idle;
- the clock holding still between divider terminal counts;
- drive and sample events never coinciding.

Only the directed scenarios can show the bit order, the framing and parity contents on the line, the length of a half period, and correct error flags on corrupted frames. They also cover which edge a slave samples and drives on, with the bench moving data mid-slot so that a wrong edge gives the wrong bit, and the 0xFF character a slave sends when it has no byte.

// File: rtl/sxc_pkg.sv
package sxc_pkg;

    localparam int FRAME_MAX = 12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DONE
    } sxc_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } rx_word_t;

    // number of bit slots in one frame
    function automatic logic [3:0] frame_len(logic framed, logic par_en, logic two_stop);
        if (framed)
            return 4'd10 + {3'b000, par_en} + {3'b000, two_stop};
        return 4'd8;
    endfunction

    // line bits of a frame, slot 0 in bit 0; unused slots read as 1
    function automatic logic [FRAME_MAX-1:0] build_frame(logic [7:0] d, logic framed,
                                                         logic par_en, logic par_odd);
        logic [FRAME_MAX-1:0] f;
        f = '1;
        if (framed) begin
            f[0]   = 1'b0;
            f[8:1] = d;
            if (par_en)
                f[9] = (^d) ^ par_odd;
        end else begin
            f[7:0] = d;
        end
        return f;
    endfunction

    function automatic rx_word_t decode_frame(logic [FRAME_MAX-1:0] b, logic framed,
                                              logic par_en, logic par_odd, logic two_stop);
        rx_word_t   r;
        logic [3:0] sp;
        sp     = par_en ? 4'd10 : 4'd9;
        r.data = framed ? b[8:1] : b[7:0];
        r.perr = framed && par_en && ((^b[8:1]) ^ b[9] ^ par_odd);
        r.ferr = framed && (!b[sp] || (two_stop && !b[sp + 4'd1]));
        return r;
    endfunction

endpackage

// File: rtl/sxc_pin_sync.sv
module sxc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic sd_in,
    output logic sd_s,
    output logic sck_rise,
    output logic sck_fall
);
    logic [STAGES-1:0] sck_pipe;
    logic [STAGES-1:0] sd_pipe;
    logic              sck_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe <= '0;
            sd_pipe  <= '1;
            sck_prev <= 1'b0;
        end else begin
            sck_pipe <= {sck_pipe[STAGES-2:0], sck_in};
            sd_pipe  <= {sd_pipe[STAGES-2:0], sd_in};
            sck_prev <= sck_pipe[STAGES-1];
        end
    end

    assign sd_s     = sd_pipe[STAGES-1];
    assign sck_rise = sck_pipe[STAGES-1] && !sck_prev;
    assign sck_fall = !sck_pipe[STAGES-1] && sck_prev;

endmodule

// File: rtl/sxc_clk_master.sv
module sxc_clk_master #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clk_inv,
    input  logic [DIV_W-1:0] half_div,
    output logic             sck_out,
    output logic             drive_p,
    output logic             sample_p
);
    logic [DIV_W-1:0] cnt;
    logic             sck_q;
    logic             toggle;
    logic             mark;

    assign mark   = !clk_inv;
    assign toggle = run && (cnt == half_div);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            sck_q <= mark;
        end else if (toggle) begin
            cnt   <= '0;
            sck_q <= !sck_q;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    assign sck_out  = sck_q;
    assign drive_p  = toggle && (sck_q == mark);
    assign sample_p = toggle && (sck_q != mark);

    // R7
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && (cnt != half_div) |=> $stable(sck_q));

endmodule

// File: rtl/sxc_frame_fsm.sv
module sxc_frame_fsm
    import sxc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master,
    input  logic       framed,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    input  logic       drive_p,
    input  logic       sample_p,
    input  logic       sd_in_s,
    output logic       sd_out,
    output logic       run,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_par_err,
    output logic       rx_frm_err
);
    sxc_state_t           state, state_nx;
    logic [FRAME_MAX-1:0] tx_sh;
    logic [FRAME_MAX-1:0] rx_bits;
    logic [FRAME_MAX-1:0] rx_now;
    logic [FRAME_MAX-1:0] frame_now;
    logic [3:0]           bit_cnt;
    logic [3:0]           frame_n;
    logic                 slave_kick;
    logic                 take;
    logic                 last_sample;
    rx_word_t             word;

    assign frame_n     = frame_len(framed, par_en, two_stop);
    assign slave_kick  = !master && drive_p;
    assign take        = (state == ST_IDLE) && (tx_valid || slave_kick);
    assign last_sample = (state == ST_SHIFT) && sample_p && (bit_cnt == frame_n - 4'd1);
    assign frame_now   = build_frame(tx_valid ? tx_data : 8'hFF, framed, par_en, par_odd);
    assign tx_ready    = (state == ST_IDLE);
    assign run         = master && (state == ST_SHIFT);

    always_comb begin
        rx_now          = rx_bits;
        rx_now[bit_cnt] = sd_in_s;
    end

    assign word = decode_frame(rx_now, framed, par_en, par_odd, two_stop);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (take) state_nx = ST_SHIFT;
            ST_SHIFT: if (last_sample) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh      <= '1;
            rx_bits    <= '0;
            bit_cnt    <= '0;
            sd_out     <= 1'b1;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_par_err <= 1'b0;
            rx_frm_err <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        bit_cnt <= '0;
                        rx_bits <= '0;
                        if (slave_kick) begin
                            sd_out <= frame_now[0];
                            tx_sh  <= {1'b1, frame_now[FRAME_MAX-1:1]};
                        end else begin
                            tx_sh  <= frame_now;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (drive_p) begin
                        sd_out <= tx_sh[0];
                        tx_sh  <= {1'b1, tx_sh[FRAME_MAX-1:1]};
                    end
                    if (sample_p) begin
                        rx_bits <= rx_now;
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (last_sample) begin
                        rx_valid   <= 1'b1;
                        rx_data    <= word.data;
                        rx_par_err <= word.perr;
                        rx_frm_err <= word.ferr;
                    end
                end
                ST_DONE: sd_out <= 1'b1;
                default: sd_out <= 1'b1;
            endcase
        end
    end

    // R10
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_ready);

    // R2
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (bit_cnt < 4'(FRAME_MAX)));

    // R12
    line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> sd_out);

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_master,
    input  logic             cfg_frame_en,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_two_stop,
    input  logic             cfg_clk_inv,
    input  logic [DIV_W-1:0] cfg_half_div,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_par_err,
    output logic             rx_frm_err,
    input  logic             sd_in,
    output logic             sd_out,
    input  logic             sck_in,
    output logic             sck_out,
    output logic             sck_oe
);
    logic sd_s, s_rise, s_fall;
    logic m_drive, m_sample, run;
    logic drive_p, sample_p;

    sxc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_in   (sck_in),
        .sd_in    (sd_in),
        .sd_s     (sd_s),
        .sck_rise (s_rise),
        .sck_fall (s_fall)
    );

    sxc_clk_master #(.DIV_W(DIV_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .clk_inv  (cfg_clk_inv),
        .half_div (cfg_half_div),
        .sck_out  (sck_out),
        .drive_p  (m_drive),
        .sample_p (m_sample)
    );

    // slave: drive edge leaves the mark level, sample edge returns to it
    assign drive_p  = cfg_master ? m_drive  : (cfg_clk_inv ? s_rise : s_fall);
    assign sample_p = cfg_master ? m_sample : (cfg_clk_inv ? s_fall : s_rise);
    assign sck_oe   = cfg_master;

    sxc_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .master     (cfg_master),
        .framed     (cfg_frame_en),
        .par_en     (cfg_par_en),
        .par_odd    (cfg_par_odd),
        .two_stop   (cfg_two_stop),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .drive_p    (drive_p),
        .sample_p   (sample_p),
        .sd_in_s    (sd_s),
        .sd_out     (sd_out),
        .run        (run),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_par_err (rx_par_err),
        .rx_frm_err (rx_frm_err)
    );

    // R6
    mark_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_master && tx_ready && $past(tx_ready) && $stable(cfg_clk_inv)
        |-> (sck_out == !cfg_clk_inv));

    // R8
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_p && sample_p));

endmodule

// File: tb/test_sync_serial_xcvr.sv
module test_sync_serial_xcvr;
    localparam int CLK_PERIOD = 10;
    localparam int SLV_HALF   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b1, cfg_frame_en = 1'b0, cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0, cfg_two_stop = 1'b0, cfg_clk_inv = 1'b0;
    logic [7:0] cfg_half_div = 8'd3;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready, rx_valid, rx_par_err, rx_frm_err;
    logic [7:0] rx_data;
    logic       sd_out, sck_out, sck_oe, sd_in;
    logic       lb_en = 1'b1, bench_sd = 1'b1, bench_sck = 1'b1;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int got_n = 0;
    logic [7:0] got_data;
    logic got_perr, got_ferr;
    logic mon_prev = 1'b1;
    logic [15:0] mon_bits;
    int mon_n = 0, mon_tog = 0, since = 0, seg_min = 0, seg_max = 0;

    assign sd_in = lb_en ? sd_out : bench_sd;

    always #(CLK_PERIOD/2) clk = !clk;

    sync_serial_xcvr i_sync_serial_xcvr (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_frame_en(cfg_frame_en),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .cfg_clk_inv(cfg_clk_inv), .cfg_half_div(cfg_half_div), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .sd_in(sd_in), .sd_out(sd_out),
        .sck_in(bench_sck), .sck_out(sck_out), .sck_oe(sck_oe));

    // bus monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                got_n++;
                got_data = rx_data;
                got_perr = rx_par_err;
                got_ferr = rx_frm_err;
            end
            if (cfg_master) begin
                since++;
                if (sck_out != mon_prev) begin
                    if (mon_tog > 0) begin
                        if (seg_min == 0 || since < seg_min) seg_min = since;
                        if (since > seg_max) seg_max = since;
                    end
                    mon_tog++;
                    since = 0;
                    if (sck_out == !cfg_clk_inv && mon_n < 16) begin
                        mon_bits[mon_n] = sd_out;
                        mon_n++;
                    end
                end
                mon_prev = sck_out;
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic void mk_frame(input logic [7:0] d, input bit fr, input bit pe,
                                     input bit odd, input bit two,
                                     output logic [11:0] b, output int n);
        n = 0;
        b = '1;
        if (fr) begin b[n] = 1'b0; n++; end
        for (int i = 0; i < 8; i++) begin b[n] = d[i]; n++; end
        if (fr && pe) begin b[n] = odd ? !(^d) : (^d); n++; end
        if (fr) begin
            b[n] = 1'b1; n++;
            if (two) begin b[n] = 1'b1; n++; end
        end
    endfunction

    task automatic wait_rx(input int target);
        for (int i = 0; i < 4000 && got_n < target; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(input bit m, input bit fr, input bit pe, input bit odd,
                           input bit two, input bit inv, input logic [7:0] half);
        cfg_master = m; cfg_frame_en = fr; cfg_par_en = pe; cfg_par_odd = odd;
        cfg_two_stop = two; cfg_clk_inv = inv; cfg_half_div = half;
        lb_en = m; bench_sd = 1'b1; bench_sck = !inv;
        repeat (6) @(negedge clk);
    endtask

    // master mode, data looped back from sd_out to sd_in
    task automatic t_master(input logic [7:0] d, input bit fr, input bit pe, input bit odd,
                            input bit two, input bit inv, input logic [7:0] half, input string req);
        logic [11:0] eb;
        logic [15:0] mask;
        int en, base;
        set_cfg(1'b1, fr, pe, odd, two, inv, half);
        mk_frame(d, fr, pe, odd, two, eb, en);
        check(sck_out == !inv && sck_oe, {"R6 idle mark ", req}, sck_out, !inv);
        check(sd_out == 1'b1 && tx_ready, {"R12 idle line ", req}, sd_out, 1);
        mon_n = 0; mon_tog = 0; seg_min = 0; seg_max = 0; mon_prev = sck_out;
        base = got_n;
        tx_data = d; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        check(!tx_ready, {"R9 ready drop ", req}, tx_ready, 0);
        wait_rx(base + 1);
        check(got_n - base == 1, {"R10 one strobe ", req}, got_n - base, 1);
        check(got_data == d && !got_perr && !got_ferr, {"R1 loopback byte ", req}, got_data, d);
        check(mon_n == en, {"R7 clock cycles per frame ", req}, mon_n, en);
        mask = 16'((32'd1 << en) - 1);
        check((mon_bits & mask) == (16'(eb) & mask), {"R2 R3 line bits ", req}, mon_bits & mask, 16'(eb) & mask);
        check(seg_min == half + 1 && seg_max == half + 1, {"R7 half period ", req}, seg_max, half + 1);
        check(sck_out == !inv && sd_out, {"R6 R12 back to mark ", req}, sck_out, !inv);
    endtask

    // slave mode: bench drives the serial clock and data
    task automatic t_slave(input logic [7:0] rd, input bit have_tx, input logic [7:0] td,
                           input bit fr, input bit pe, input bit odd, input bit two, input bit inv,
                           input bit bad_par, input bit bad_stop, input string req);
        logic [11:0] rb, tb, cap;
        int rn, tn, base;
        set_cfg(1'b0, fr, pe, odd, two, inv, 8'd3);
        check(!sck_oe, {"R6 slave oe ", req}, sck_oe, 0);
        mk_frame(rd, fr, pe, odd, two, rb, rn);
        mk_frame(have_tx ? td : 8'hFF, fr, pe, odd, two, tb, tn);
        if (bad_par) rb[9] = !rb[9];
        if (bad_stop) rb[rn-1] = 1'b0;
        cap = '1;
        base = got_n;
        if (have_tx) begin
            tx_data = td; tx_valid = 1'b1;
            @(negedge clk);
            tx_valid = 1'b0;
            repeat (2) @(negedge clk);
        end
        for (int k = 0; k < rn; k++) begin
            bench_sck = inv;
            repeat (SLV_HALF/2) @(negedge clk);
            bench_sd = rb[k];
            repeat (SLV_HALF/2) @(negedge clk);
            bench_sck = !inv;
            cap[k] = sd_out;
            repeat (SLV_HALF) @(negedge clk);
        end
        bench_sd = 1'b1;
        wait_rx(base + 1);
        check(got_n - base == 1, {"R10 slave strobe ", req}, got_n - base, 1);
        check(got_data == rd, {"R8 slave rx byte ", req}, got_data, rd);
        check(got_perr == bad_par, {"R4 parity flag ", req}, got_perr, bad_par);
        check(got_ferr == bad_stop, {"R5 framing flag ", req}, got_ferr, bad_stop);
        check(cap == tb, {have_tx ? "R8 slave tx frame " : "R11 idle char ", req}, cap, tb);
        check(sd_out && tx_ready, {"R12 slave idle line ", req}, sd_out, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_ready == 1'b1, "R9 reset ready", tx_ready, 1);
        check(!rx_valid, "R10 reset strobe", rx_valid, 0);
        check(sd_out == 1'b1, "R12 reset line", sd_out, 1);
        check(sck_out == 1'b1, "R6 reset mark", sck_out, 1);

        t_master(8'hA5, 0, 0, 0, 0, 0, 8'd3, "bare");
        t_master(8'h3C, 0, 1, 1, 1, 1, 8'd4, "bare parity ignored R3");
        t_master(8'h81, 1, 0, 0, 0, 0, 8'd3, "framed one stop");
        t_master(8'h6E, 1, 1, 0, 1, 1, 8'd5, "even two stop");
        t_master(8'h00, 1, 1, 1, 0, 0, 8'd3, "odd one stop");

        t_slave(8'hC3, 1, 8'h5A, 0, 0, 0, 0, 0, 0, 0, "bare rising");
        t_slave(8'h96, 0, 8'h00, 1, 1, 1, 1, 1, 0, 0, "odd falling R11");
        t_slave(8'h4B, 1, 8'h71, 1, 1, 0, 0, 0, 1, 0, "bad parity");
        t_slave(8'hE2, 1, 8'h19, 1, 0, 0, 1, 1, 0, 1, "bad stop");

        finish_run();
    end

endmodule